// File: doc/BRIEF.md
# Throttled Interrupt Aggregation Controller

This block gathers the interrupt causes of a supply and bus interface controller into one cause register and drives an active-low interrupt request line towards a host processor. The host reads the cause register through a single-cycle read strobe. The read returns the causes latched so far and clears them in the same cycle. The block then holds the request line inactive for a programmable number of cycles, so that any cause still pending makes a new falling edge.

Causes fall into two classes. Urgent causes pull the request line low at once. These are a serial-interface clock-count failure, a battery supply failure and a watchdog restart while the watchdog is off. Slow causes are overtemperature, ground shift, bus failure, three regulator failures, a bus wake-up and a wake-pin wake-up. They are latched at once, but in normal mode they may pull the line low at most once per watchdog period, which a single-cycle tick input marks. Enable inputs decide, by operating mode, whether a falling edge on the wake pin or a rising edge on the bus event input becomes a wake cause or a single-cycle reset request. A watchdog-restart enable is set by a strobe and clears itself on every watchdog overflow.

Top module: `intr_aggregator`

## Requirements
- R1: While reset is active, the request line is high (inactive), the cause register reads zero, the reset request is low and the watchdog-restart enable reads zero.
- R2: The cause register has this bit layout: [0] serial clock-count failure, [1] battery failure, [2] overtemperature, [3] ground shift, [4] bus failure, [5..7] regulator 1..3 failure, [8] bus wake, [9] wake-pin wake, [10] watchdog restart. An event pulse on a source sets its bit on the next clock edge, and the bit stays set until a read.
- R3: A read strobe clears the cause register on its clock edge. A cause event in the same cycle as the read is kept and is the only content after that edge.
- R4: After the edge that takes a read, the request line is high for exactly RELEASE_CYC cycles. From the following edge it goes low again if an eligible cause is pending.
- R5: An urgent cause (bits 0, 1, 10) pulls the request line low on the second clock edge after its event, in every mode, outside the release window.
- R6: In normal mode (mode 0), slow causes (bits 2 to 9) pull the request line low at most once per watchdog period. After that signal has been cleared by a read, new slow causes are still latched but leave the line high until the edge after the next watchdog tick.
- R7: In flash (mode 1), standby (mode 2) and sleep (mode 3), a slow cause pulls the request line low on the second edge after its event, with no throttling.
- R8: With the wake-port enable and the wake-interrupt enable set, a falling edge of the wake pin sets bit 9 in normal, flash and standby mode. In sleep mode it has no effect.
- R9: With the wake-port enable set and the wake-interrupt enable clear, a wake-pin falling edge gives a one-cycle reset request in standby mode and no cause bit. In the other modes it does nothing.
- R10: With the wake-port enable clear, wake-pin edges neither set a cause nor request a reset.
- R11: With the bus-interrupt enable set, a rising edge of the bus event input sets bit 8 in standby mode. In normal or flash mode it does so only while the bus-active input is low.
- R12: With the bus-interrupt enable clear, a bus event rising edge gives a one-cycle reset request in standby mode and has no effect in the other modes.
- R13: The watchdog-restart enable is set by its set strobe and cleared by a watchdog overflow, and overflow wins when both occur together. While the enable is set, a restart pulse with the watchdog-off input high sets bit 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Operating mode: 0 normal, 1 flash, 2 standby, 3 sleep |
| urgent_evt_i | input | 2 | Urgent event pulses: [0] clock-count failure, [1] battery failure |
| slow_evt_i | input | 6 | Slow event pulses: overtemperature, ground shift, bus failure, regulators 1..3 |
| wake_pin_i | input | 1 | Synchronized wake pin level, idle high |
| wake_port_en_i | input | 1 | Global enable of the wake-pin function |
| wake_irq_en_i | input | 1 | Wake edge gives an interrupt (1) or a standby reset (0) |
| bus_evt_i | input | 1 | Bus activity level; a rising edge is a bus event |
| bus_active_i | input | 1 | Bus transceiver already active |
| bus_irq_en_i | input | 1 | Bus event gives an interrupt (1) or a standby reset (0) |
| wdog_tick_i | input | 1 | Single-cycle pulse at each watchdog period |
| wdog_overflow_i | input | 1 | Single-cycle pulse on watchdog overflow |
| wdog_restart_i | input | 1 | Single-cycle pulse on watchdog restart |
| wdog_off_i | input | 1 | Watchdog is currently off |
| wdr_en_set_i | input | 1 | Strobe that sets the watchdog-restart enable |
| rd_strobe_i | input | 1 | Read of the cause register (clears it) |
| cause_o | output | 11 | Cause register contents |
| irq_n_o | output | 1 | Active-low interrupt request line |
| rst_req_o | output | 1 | Single-cycle reset request |
| wdr_en_o | output | 1 | Current watchdog-restart enable |

## Verification
The hardest state to reach is a throttled period in normal mode: the single slow signal allowed in the period has already been spent and cleared by a read, and a new slow cause is pending with no tick yet. The bench gets there by raising one slow cause and reading it back with no tick in between. It then raises a second slow cause and checks that the line stays high while the cause bit is set. Only after that does it pulse the tick and expect the line to fall one edge later. A read with an urgent event in the same cycle covers the lost-event hazard and the exact length of the release window.

// File: rtl/intr_agg_pkg.sv
// Shared definitions for the interrupt aggregation controller: operating
// modes, the cause register layout and the class masks derived from it.
package intr_agg_pkg;

    typedef enum logic [1:0] {
        OPM_NORMAL  = 2'd0,
        OPM_FLASH   = 2'd1,
        OPM_STANDBY = 2'd2,
        OPM_SLEEP   = 2'd3
    } opmode_e;

    localparam int N_URG        = 2;
    localparam int N_SLOW       = 6;
    localparam int BIT_BUS_WAKE = N_URG + N_SLOW;
    localparam int BIT_PIN_WAKE = BIT_BUS_WAKE + 1;
    localparam int BIT_WDR      = BIT_PIN_WAKE + 1;
    localparam int CAUSE_W      = BIT_WDR + 1;

    // Bits whose pending state pulls the request line immediately.
    function automatic logic [CAUSE_W-1:0] urgent_mask();
        logic [CAUSE_W-1:0] m;
        m = '0;
        for (int i = 0; i < N_URG; i++) m[i] = 1'b1;
        m[BIT_WDR] = 1'b1;
        return m;
    endfunction

    // Bits that are rate limited in normal mode.
    function automatic logic [CAUSE_W-1:0] slow_mask();
        logic [CAUSE_W-1:0] m;
        m = '0;
        for (int i = N_URG; i <= BIT_PIN_WAKE; i++) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/event_router.sv
// Turns wake-pin edges, bus event edges and watchdog restarts into cause
// set pulses or a registered reset request, according to mode and enables.
// Assumes wake_pin_i and bus_evt_i are already synchronous to clk.
module event_router
    import intr_agg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  opmode_e mode,
    input  logic    wake_pin_i,
    input  logic    wake_port_en_i,
    input  logic    wake_irq_en_i,
    input  logic    bus_evt_i,
    input  logic    bus_active_i,
    input  logic    bus_irq_en_i,
    input  logic    wdog_overflow_i,
    input  logic    wdog_restart_i,
    input  logic    wdog_off_i,
    input  logic    wdr_en_set_i,
    output logic    bus_cause_o,
    output logic    pin_cause_o,
    output logic    wdr_cause_o,
    output logic    rst_req_o,
    output logic    wdr_en_o
);

    logic pin_prev_q;
    logic bus_prev_q;
    logic rst_req_q;
    logic wdr_en_q;
    logic pin_fall;
    logic bus_rise;
    logic pin_rst;
    logic bus_rst;
    logic awake_active;

    // Remember previous input levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_prev_q <= 1'b1;
            bus_prev_q <= 1'b0;
        end else begin
            pin_prev_q <= wake_pin_i;
            bus_prev_q <= bus_evt_i;
        end
    end

    // Edge detection and mode-dependent routing.
    always_comb begin
        pin_fall     = wake_port_en_i & pin_prev_q & ~wake_pin_i;
        bus_rise     = bus_evt_i & ~bus_prev_q;
        awake_active = (mode == OPM_NORMAL) || (mode == OPM_FLASH);
        pin_cause_o  = pin_fall & wake_irq_en_i & (mode != OPM_SLEEP);
        pin_rst      = pin_fall & ~wake_irq_en_i & (mode == OPM_STANDBY);
        bus_cause_o  = bus_rise & bus_irq_en_i &
                       ((mode == OPM_STANDBY) | (awake_active & ~bus_active_i));
        bus_rst      = bus_rise & ~bus_irq_en_i & (mode == OPM_STANDBY);
        wdr_cause_o  = wdog_restart_i & wdog_off_i & wdr_en_q;
    end

    // Register the reset request so it leaves as a clean pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req_q <= 1'b0;
        else        rst_req_q <= pin_rst | bus_rst;
    end

    // Watchdog-restart enable: set by strobe, overflow clears with priority.
    always_ff @(posedge clk) begin
        if (!rst_n)               wdr_en_q <= 1'b0;
        else if (wdog_overflow_i) wdr_en_q <= 1'b0;
        else if (wdr_en_set_i)    wdr_en_q <= 1'b1;
    end

    assign rst_req_o = rst_req_q;
    assign wdr_en_o  = wdr_en_q;

endmodule

// File: rtl/cause_latch.sv
// Sticky cause register, cleared by a read. A set pulse in the read cycle
// wins over the clear, so no event is lost across a read.
module cause_latch #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         rd_i,
    output logic [W-1:0] cause_o
);

    logic [W-1:0] cause_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        // One sticky flag per cause bit.
        always_ff @(posedge clk) begin
            if (!rst_n) cause_q[b] <= 1'b0;
            else        cause_q[b] <= (cause_q[b] & ~rd_i) | set_i[b];
        end
    end

    assign cause_o = cause_q;

endmodule

// File: rtl/irq_throttle.sv
// Drives the registered active-low request line from the pending causes.
// Urgent bits pass at once. Slow bits pass once per watchdog period in normal
// mode, and freely elsewhere. A read opens a release window of RELEASE_CYC cycles.
module irq_throttle
    import intr_agg_pkg::*;
#(
    parameter int           W           = 11,
    parameter int           RELEASE_CYC = 8,
    parameter logic [W-1:0] URG_MASK    = '0,
    parameter logic [W-1:0] SLOW_MASK   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  opmode_e      mode,
    input  logic [W-1:0] cause_i,
    input  logic         rd_i,
    input  logic         tick_i,
    output logic         irq_n_o
);

    localparam int             CNT_W  = $clog2(RELEASE_CYC + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(RELEASE_CYC - 1);

    logic [CNT_W-1:0] rel_cnt_q;
    logic             armed_q;
    logic             shown_q;
    logic             irq_n_q;
    logic             in_rel;
    logic             urg_pend;
    logic             slow_pend;
    logic             normal;
    logic             fire;
    logic             slow_vis;
    logic             want;

    // Decide whether the line should be active after this edge.
    always_comb begin
        in_rel    = (rel_cnt_q != '0);
        urg_pend  = |(cause_i & URG_MASK);
        slow_pend = |(cause_i & SLOW_MASK);
        normal    = (mode == OPM_NORMAL);
        fire      = normal & armed_q & slow_pend & ~shown_q & ~in_rel & ~rd_i;
        slow_vis  = normal ? (shown_q | fire) : slow_pend;
        want      = ~rd_i & ~in_rel & (urg_pend | slow_vis);
    end

    // Release window counter, loaded by each read.
    always_ff @(posedge clk) begin
        if (!rst_n)      rel_cnt_q <= '0;
        else if (rd_i)   rel_cnt_q <= RELOAD;
        else if (in_rel) rel_cnt_q <= rel_cnt_q - 1'b1;
    end

    // Throttle gate: spent by a slow signal, restored by the period tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      armed_q <= 1'b1;
        else if (fire)   armed_q <= 1'b0;
        else if (tick_i) armed_q <= 1'b1;
    end

    // Hold a granted slow signal until the host reads.
    always_ff @(posedge clk) begin
        if (!rst_n)    shown_q <= 1'b0;
        else if (rd_i) shown_q <= 1'b0;
        else if (fire) shown_q <= 1'b1;
    end

    // Registered request line for a glitch-free output.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n_q <= 1'b1;
        else        irq_n_q <= ~want;
    end

    assign irq_n_o = irq_n_q;

endmodule

// File: rtl/intr_aggregator.sv
// Top of the throttled interrupt aggregation controller. Assembles the
// cause vector, latches it, and drives the request and reset-request lines.
// Assumes all event inputs are synchronous single-cycle pulses, except
// wake_pin_i and bus_evt_i which are levels whose edges are detected.
module intr_aggregator
    import intr_agg_pkg::*;
#(
    parameter int RELEASE_CYC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_i,
    input  logic [N_URG-1:0]   urgent_evt_i,
    input  logic [N_SLOW-1:0]  slow_evt_i,
    input  logic               wake_pin_i,
    input  logic               wake_port_en_i,
    input  logic               wake_irq_en_i,
    input  logic               bus_evt_i,
    input  logic               bus_active_i,
    input  logic               bus_irq_en_i,
    input  logic               wdog_tick_i,
    input  logic               wdog_overflow_i,
    input  logic               wdog_restart_i,
    input  logic               wdog_off_i,
    input  logic               wdr_en_set_i,
    input  logic               rd_strobe_i,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               irq_n_o,
    output logic               rst_req_o,
    output logic               wdr_en_o
);

    localparam logic [CAUSE_W-1:0] URG_M  = urgent_mask();
    localparam logic [CAUSE_W-1:0] SLOW_M = slow_mask();

    opmode_e            mode;
    logic               bus_cause;
    logic               pin_cause;
    logic               wdr_cause;
    logic [CAUSE_W-1:0] set_vec;
    logic [CAUSE_W-1:0] cause;

    assign mode    = opmode_e'(mode_i);
    assign set_vec = {wdr_cause, pin_cause, bus_cause, slow_evt_i, urgent_evt_i};

    event_router u_router (
        .clk             (clk),
        .rst_n           (rst_n),
        .mode            (mode),
        .wake_pin_i      (wake_pin_i),
        .wake_port_en_i  (wake_port_en_i),
        .wake_irq_en_i   (wake_irq_en_i),
        .bus_evt_i       (bus_evt_i),
        .bus_active_i    (bus_active_i),
        .bus_irq_en_i    (bus_irq_en_i),
        .wdog_overflow_i (wdog_overflow_i),
        .wdog_restart_i  (wdog_restart_i),
        .wdog_off_i      (wdog_off_i),
        .wdr_en_set_i    (wdr_en_set_i),
        .bus_cause_o     (bus_cause),
        .pin_cause_o     (pin_cause),
        .wdr_cause_o     (wdr_cause),
        .rst_req_o       (rst_req_o),
        .wdr_en_o        (wdr_en_o)
    );

    cause_latch #(.W(CAUSE_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .rd_i    (rd_strobe_i),
        .cause_o (cause)
    );

    irq_throttle #(
        .W           (CAUSE_W),
        .RELEASE_CYC (RELEASE_CYC),
        .URG_MASK    (URG_M),
        .SLOW_MASK   (SLOW_M)
    ) u_throttle (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .cause_i (cause),
        .rd_i    (rd_strobe_i),
        .tick_i  (wdog_tick_i),
        .irq_n_o (irq_n_o)
    );

    assign cause_o = cause;

endmodule

// File: rtl/intr_aggregator_chk.sv
// Port-level properties of the aggregation controller, bound to its top.
module intr_aggregator_chk
    import intr_agg_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         mode_i,
    input logic               wdog_overflow_i,
    input logic               rd_strobe_i,
    input logic [CAUSE_W-1:0] cause_o,
    input logic               irq_n_o,
    input logic               rst_req_o,
    input logic               wdr_en_o
);

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe_i |=> ((cause_o & $past(cause_o)) == $past(cause_o))); // R2

    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe_i |=> irq_n_o); // R4

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> (cause_o != '0)); // R5

    AST_RST_ONLY_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != OPM_STANDBY) |=> !rst_req_o); // R12

    AST_OVERFLOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_overflow_i |=> !wdr_en_o); // R13

    AST_SLEEP_NO_PIN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == OPM_SLEEP && !rd_strobe_i) |=>
        (cause_o[BIT_PIN_WAKE] == $past(cause_o[BIT_PIN_WAKE]))); // R8

endmodule

bind intr_aggregator intr_aggregator_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .mode_i          (mode_i),
    .wdog_overflow_i (wdog_overflow_i),
    .rd_strobe_i     (rd_strobe_i),
    .cause_o         (cause_o),
    .irq_n_o         (irq_n_o),
    .rst_req_o       (rst_req_o),
    .wdr_en_o        (wdr_en_o)
);

// File: tb/test_intr_aggregator.sv
// Scoreboard bench: the driver queues expected port values, and a monitor
// compares them 2 ns after the following rising edge.
module test_intr_aggregator;

    localparam int REL = 8;
    localparam int P_IRQ = 0, P_CAUSE = 1, P_RST = 2, P_WDR = 3;

    typedef struct {
        int          port;
        logic [15:0] exp;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic [1:0]  urgent_evt_i = '0;
    logic [5:0]  slow_evt_i = '0;
    logic        wake_pin_i = 1'b1;
    logic        wake_port_en_i = 1'b0;
    logic        wake_irq_en_i = 1'b0;
    logic        bus_evt_i = 1'b0;
    logic        bus_active_i = 1'b0;
    logic        bus_irq_en_i = 1'b0;
    logic        wdog_tick_i = 1'b0;
    logic        wdog_overflow_i = 1'b0;
    logic        wdog_restart_i = 1'b0;
    logic        wdog_off_i = 1'b0;
    logic        wdr_en_set_i = 1'b0;
    logic        rd_strobe_i = 1'b0;
    logic [10:0] cause_o;
    logic        irq_n_o;
    logic        rst_req_o;
    logic        wdr_en_o;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    intr_aggregator #(.RELEASE_CYC(REL)) i_intr_aggregator (
        .clk (clk), .rst_n (rst_n), .mode_i (mode_i),
        .urgent_evt_i (urgent_evt_i), .slow_evt_i (slow_evt_i),
        .wake_pin_i (wake_pin_i), .wake_port_en_i (wake_port_en_i),
        .wake_irq_en_i (wake_irq_en_i), .bus_evt_i (bus_evt_i),
        .bus_active_i (bus_active_i), .bus_irq_en_i (bus_irq_en_i),
        .wdog_tick_i (wdog_tick_i), .wdog_overflow_i (wdog_overflow_i),
        .wdog_restart_i (wdog_restart_i), .wdog_off_i (wdog_off_i),
        .wdr_en_set_i (wdr_en_set_i), .rd_strobe_i (rd_strobe_i),
        .cause_o (cause_o), .irq_n_o (irq_n_o),
        .rst_req_o (rst_req_o), .wdr_en_o (wdr_en_o)
    );

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // Queue an expectation for the port value after the next rising edge.
    task automatic expect_v(int port, logic [15:0] v, string r);
        item_t it;
        it.port = port;
        it.exp  = v;
        it.req  = r;
        q.push_back(it);
    endtask

    // Read and clear the causes, then let the release window run out.
    task automatic do_read();
        rd_strobe_i = 1'b1;
        expect_v(P_CAUSE, 16'h0, "R3");
        expect_v(P_IRQ, 16'h1, "R4");
        step(1);
        rd_strobe_i = 1'b0;
        step(REL + 1);
    endtask

    // Monitor: compare the queued items against the ports.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = q.pop_front();
                case (it.port)
                    P_IRQ:   act = {15'd0, irq_n_o};
                    P_CAUSE: act = {5'd0, cause_o};
                    P_RST:   act = {15'd0, rst_req_o};
                    default: act = {15'd0, wdr_en_o};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s port=%0d actual=%0h expected=%0h", it.req, it.port, act, it.exp);
                end
            end
        end
    end

    // Watchdog for a hung run.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(2);
        expect_v(P_IRQ, 16'h1, "R1");
        expect_v(P_CAUSE, 16'h0, "R1");
        expect_v(P_RST, 16'h0, "R1");
        expect_v(P_WDR, 16'h0, "R1");
        step(1);
        rst_n = 1'b1;
        step(2);

        // R5 / R2: urgent cause, immediate and sticky
        urgent_evt_i[0] = 1'b1;
        expect_v(P_CAUSE, 16'h001, "R2");
        expect_v(P_IRQ, 16'h1, "R5");
        step(1);
        urgent_evt_i[0] = 1'b0;
        expect_v(P_IRQ, 16'h0, "R5");
        step(3);
        expect_v(P_CAUSE, 16'h001, "R2");
        expect_v(P_IRQ, 16'h0, "R5");
        step(1);

        // R3 / R4: read with a coincident event, exact release window
        rd_strobe_i = 1'b1;
        urgent_evt_i[1] = 1'b1;
        expect_v(P_CAUSE, 16'h002, "R3");
        expect_v(P_IRQ, 16'h1, "R4");
        step(1);
        rd_strobe_i = 1'b0;
        urgent_evt_i[1] = 1'b0;
        for (int k = 1; k < REL; k++) begin
            expect_v(P_IRQ, 16'h1, "R4");
            step(1);
        end
        expect_v(P_IRQ, 16'h0, "R4");
        step(1);
        do_read();

        // R6: throttling in normal mode
        slow_evt_i[0] = 1'b1;
        step(1);
        slow_evt_i[0] = 1'b0;
        expect_v(P_IRQ, 16'h0, "R6");
        expect_v(P_CAUSE, 16'h004, "R6");
        step(1);
        do_read();
        slow_evt_i[1] = 1'b1;
        step(1);
        slow_evt_i[1] = 1'b0;
        step(3);
        expect_v(P_IRQ, 16'h1, "R6");
        expect_v(P_CAUSE, 16'h008, "R6");
        step(1);
        wdog_tick_i = 1'b1;
        step(1);
        wdog_tick_i = 1'b0;
        expect_v(P_IRQ, 16'h0, "R6");
        step(1);
        do_read();

        // R7: no throttling outside normal mode
        mode_i = 2'd2;
        slow_evt_i[2] = 1'b1;
        step(1);
        slow_evt_i[2] = 1'b0;
        expect_v(P_IRQ, 16'h0, "R7");
        expect_v(P_CAUSE, 16'h010, "R7");
        step(1);
        do_read();
        mode_i = 2'd1;
        slow_evt_i[3] = 1'b1;
        step(1);
        slow_evt_i[3] = 1'b0;
        expect_v(P_IRQ, 16'h0, "R7");
        step(1);
        do_read();

        // R8: wake pin interrupt
        mode_i = 2'd2;
        wake_port_en_i = 1'b1;
        wake_irq_en_i = 1'b1;
        wake_pin_i = 1'b0;
        expect_v(P_CAUSE, 16'h200, "R8");
        expect_v(P_RST, 16'h0, "R8");
        step(1);
        wake_pin_i = 1'b1;
        step(1);
        do_read();
        mode_i = 2'd3;
        wake_pin_i = 1'b0;
        step(1);
        wake_pin_i = 1'b1;
        step(2);
        expect_v(P_CAUSE, 16'h000, "R8");
        expect_v(P_IRQ, 16'h1, "R8");
        step(1);

        // R9: wake pin reset request
        mode_i = 2'd2;
        wake_irq_en_i = 1'b0;
        wake_pin_i = 1'b0;
        expect_v(P_RST, 16'h1, "R9");
        expect_v(P_CAUSE, 16'h000, "R9");
        step(1);
        wake_pin_i = 1'b1;
        expect_v(P_RST, 16'h0, "R9");
        step(2);
        mode_i = 2'd0;
        wake_pin_i = 1'b0;
        expect_v(P_RST, 16'h0, "R9");
        expect_v(P_CAUSE, 16'h000, "R9");
        step(1);
        wake_pin_i = 1'b1;
        step(2);

        // R10: wake port globally disabled
        mode_i = 2'd2;
        wake_port_en_i = 1'b0;
        wake_irq_en_i = 1'b1;
        wake_pin_i = 1'b0;
        expect_v(P_CAUSE, 16'h000, "R10");
        expect_v(P_RST, 16'h0, "R10");
        step(1);
        wake_pin_i = 1'b1;
        step(1);
        wake_irq_en_i = 1'b0;
        wake_pin_i = 1'b0;
        expect_v(P_RST, 16'h0, "R10");
        step(1);
        wake_pin_i = 1'b1;
        step(2);

        // R11: bus wake interrupt
        bus_irq_en_i = 1'b1;
        bus_evt_i = 1'b1;
        expect_v(P_CAUSE, 16'h100, "R11");
        step(1);
        bus_evt_i = 1'b0;
        step(1);
        do_read();
        mode_i = 2'd0;
        bus_active_i = 1'b1;
        bus_evt_i = 1'b1;
        step(1);
        bus_evt_i = 1'b0;
        step(2);
        expect_v(P_CAUSE, 16'h000, "R11");
        step(1);
        bus_active_i = 1'b0;
        bus_evt_i = 1'b1;
        expect_v(P_CAUSE, 16'h100, "R11");
        step(1);
        bus_evt_i = 1'b0;
        step(1);
        do_read();
        mode_i = 2'd1;
        bus_evt_i = 1'b1;
        expect_v(P_CAUSE, 16'h100, "R11");
        step(1);
        bus_evt_i = 1'b0;
        step(1);
        do_read();

        // R12: bus reset request
        mode_i = 2'd2;
        bus_irq_en_i = 1'b0;
        bus_evt_i = 1'b1;
        expect_v(P_RST, 16'h1, "R12");
        expect_v(P_CAUSE, 16'h000, "R12");
        step(1);
        bus_evt_i = 1'b0;
        expect_v(P_RST, 16'h0, "R12");
        step(1);
        mode_i = 2'd1;
        bus_evt_i = 1'b1;
        expect_v(P_RST, 16'h0, "R12");
        expect_v(P_CAUSE, 16'h000, "R12");
        step(1);
        bus_evt_i = 1'b0;
        step(1);

        // R13: watchdog-restart enable and cause
        mode_i = 2'd0;
        wdr_en_set_i = 1'b1;
        expect_v(P_WDR, 16'h1, "R13");
        step(1);
        wdr_en_set_i = 1'b0;
        wdog_off_i = 1'b1;
        wdog_restart_i = 1'b1;
        expect_v(P_CAUSE, 16'h400, "R13");
        step(1);
        wdog_restart_i = 1'b0;
        expect_v(P_IRQ, 16'h0, "R13");
        step(1);
        do_read();
        wdog_off_i = 1'b0;
        wdog_restart_i = 1'b1;
        step(1);
        wdog_restart_i = 1'b0;
        step(1);
        expect_v(P_CAUSE, 16'h000, "R13");
        step(1);
        wdog_overflow_i = 1'b1;
        expect_v(P_WDR, 16'h0, "R13");
        step(1);
        wdog_overflow_i = 1'b0;
        wdog_off_i = 1'b1;
        wdog_restart_i = 1'b1;
        step(1);
        wdog_restart_i = 1'b0;
        step(1);
        expect_v(P_CAUSE, 16'h000, "R13");
        step(1);
        wdr_en_set_i = 1'b1;
        wdog_overflow_i = 1'b1;
        expect_v(P_WDR, 16'h0, "R13");
        step(1);
        wdog_overflow_i = 1'b0;
        step(3);
        expect_v(P_WDR, 16'h1, "R13");
        step(1);
        wdr_en_set_i = 1'b0;
        step(3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule